// File: doc/BRIEF.md
# CEC Transmit Frame Sequencer

This block stages one outgoing CEC message of 1 to 16 bytes and hands it, one byte at a time, to a byte-level CEC transmitter. The host first streams the message bytes into a local buffer, then issues a start request carrying the message length. While the message is in flight the block decorates each byte with three tags: a start-bit request on the first byte, an end-of-message marker on the final byte, and a broadcast-mode marker on every byte when the destination nibble of the header byte is all ones.

The downstream transmitter is seen only as a byte stream plus three status pulses: frame sent, frame refused (NAK) and holding-register underrun. The block drives an interrupt-enable mask and a status-clear strobe toward that transmitter, in the way a driver would. When a frame ends refused, or the transmitter underruns, the block replays a controller reset on the control word it passes through. It snapshots the word, drives zero, clears every status bit, then restores the snapshot.

Both byte interfaces use valid/ready. A byte moves on a clock edge where valid and ready are both high. A source that raises valid keeps it and its data steady until ready is seen. The load port deasserts ready when the buffer is full or a message is in flight. The transmit port holds its byte and tags steady for as long as the transmitter withholds ready.

Top module: `cec_tx_sequencer`

## Requirements
- R1: `in_ready` is high exactly when no message is in flight and fewer than 16 bytes have been loaded since the last accepted start; loaded bytes fill the buffer from index 0 upward.
- R2: A start request with a length from 1 to 16 while idle raises `busy_o` on the next cycle. It sets mask bits 0 (empty), 1 (sent) and 2 (NAK) of `irq_mask_o`. `busy_o` stays high until the message completes.
- R3: A start request with length 0 or above 16 leaves the block idle and sets `err_o`; `err_o` clears on the next accepted start.
- R4: While bytes remain, `tx_valid` is high and `tx_data` holds buffer byte `idx`. `tx_data` and the tags hold steady while `tx_ready` is low. The index advances by one on each handshake.
- R5: `tx_start` is high on byte 0 only.
- R6: `tx_eom` is high on byte length-1 only.
- R7: `tx_bcast` is high on every byte when bits [3:0] of byte 0 equal 4'hF, and low on every byte otherwise.
- R8: Each handshake pulses `irq_clr_o` bit 0 on the following cycle. Once the last byte is handed over, `tx_valid` falls and mask bit 0 clears.
- R9: `frame_done` while busy pulses `done_o` and drops `busy_o` on the next cycle. It clears mask bits 1 and 2 and pulses `irq_clr_o` bit 1. `frame_done` while idle has no effect.
- R10: `frame_nak` together with an accepted `frame_done` sets `refused_o`, which holds until the next accepted start. It also pulses `irq_clr_o` bit 2 and starts a controller reset.
- R11: `underrun` pulses `wake_o` on the next cycle and starts a controller reset. Transmission of the current message continues.
- R12: A controller reset spans three cycles after the trigger. In the first, `ctrl_o` is zero. In the second, `ctrl_o` is zero and `irq_clr_o` is all ones. In the third, `ctrl_o` equals the `ctrl_cfg` captured at the trigger. After that, `ctrl_o` follows `ctrl_cfg`.
- R13: A start request while busy is ignored: the message in flight continues and `err_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Load byte valid |
| in_ready | output | 1 | Buffer can take a byte |
| in_data | input | 8 | Load byte |
| start_req | input | 1 | Start pulse |
| start_len | input | 5 | Message length for the start |
| busy_o | output | 1 | Message in flight |
| done_o | output | 1 | Message completed (pulse) |
| refused_o | output | 1 | Last message ended with NAK |
| err_o | output | 1 | Last start had an illegal length |
| wake_o | output | 1 | Underrun seen (pulse) |
| tx_valid | output | 1 | Byte available for transmitter |
| tx_ready | input | 1 | Transmitter holding register empty |
| tx_data | output | 8 | Byte to transmit |
| tx_start | output | 1 | Generate start bit tag |
| tx_eom | output | 1 | End-of-message tag |
| tx_bcast | output | 1 | Broadcast address mode tag |
| frame_done | input | 1 | Transmitter finished frame |
| frame_nak | input | 1 | Frame was refused |
| underrun | input | 1 | Transmitter underran |
| ctrl_cfg | input | 32 | Control word from host |
| ctrl_o | output | 32 | Control word to transmitter |
| irq_mask_o | output | 3 | Enables: 0 empty, 1 sent, 2 NAK |
| irq_clr_o | output | 4 | Status clear strobe: 0 empty, 1 sent, 2 NAK, 3 underrun |

## Verification
The bench walks messages of length 1, 2, 3, 5 and 16. Broadcast and directed headers are both covered, and some messages hold `tx_ready` low before each byte. A design that tagged by the wrong index would put the start or end marker on a neighbour byte. One that decoded the wrong nibble would miss the broadcast case. One that advanced without a handshake would skip bytes under back-pressure. The reset sequence is checked with `ctrl_cfg` changed mid-sequence, which exposes a restore that reads the live word instead of the snapshot. Illegal lengths 0 and 17, a start while busy and a completion while idle are all checked to leave busy, error and output state as required.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  localparam int IRQ_W     = 4;
  localparam int MASK_W    = 3;
  localparam int IRQ_EMPTY = 0;
  localparam int IRQ_DONE  = 1;
  localparam int IRQ_NAK   = 2;
  localparam int IRQ_UNDER = 3;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_SEND, SEQ_WAIT} seq_state_e;
  typedef enum logic [1:0] {RST_OFF, RST_ZERO, RST_CLEAR, RST_RESTORE} rst_phase_e;

  typedef struct packed {
    logic start;
    logic eom;
    logic bcast;
  } tx_tag_t;
endpackage

// File: rtl/cec_msg_buffer.sv
module cec_msg_buffer #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              clear_fill,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] hdr_addr
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [LEN_W-1:0]  fill;
  logic              push;

  assign in_ready = !busy && (fill < LEN_W'(DEPTH));
  assign push     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fill <= '0;
    else if (clear_fill) fill <= '0;
    else if (push)       fill <= fill + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[fill[IDX_W-1:0]] <= in_data;
  end

  assign rd_data  = mem[rd_idx];
  assign hdr_addr = mem[0][ADDR_W-1:0];

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> fill < LEN_W'(DEPTH));
  p_busy_blocks_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

// File: rtl/cec_tag_gen.sv
module cec_tag_gen
  import cec_tx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] hdr_addr,
  output tx_tag_t           tag
);
  logic [LEN_W-1:0] idx_ext;

  always_comb begin
    idx_ext   = LEN_W'(idx);
    tag.start = (idx == '0);
    tag.eom   = (idx_ext == len - 1'b1);
    tag.bcast = (hdr_addr == {ADDR_W{1'b1}});
  end
endmodule

// File: rtl/cec_ctl_reset.sv
module cec_ctl_reset
  import cec_tx_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [CTRL_W-1:0] ctrl_cfg,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              clr_all
);
  rst_phase_e        phase;
  logic [CTRL_W-1:0] saved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= RST_OFF;
      saved <= '0;
    end else begin
      unique case (phase)
        RST_OFF: if (trig) begin
          phase <= RST_ZERO;
          saved <= ctrl_cfg;
        end
        RST_ZERO:    phase <= RST_CLEAR;
        RST_CLEAR:   phase <= RST_RESTORE;
        RST_RESTORE: phase <= RST_OFF;
        default:     phase <= RST_OFF;
      endcase
    end
  end

  always_comb begin
    clr_all = (phase == RST_CLEAR);
    unique case (phase)
      RST_ZERO, RST_CLEAR: ctrl_o = '0;
      RST_RESTORE:         ctrl_o = saved;
      default:             ctrl_o = ctrl_cfg;
    endcase
  end

  p_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
    phase == RST_CLEAR |-> $past(phase) == RST_ZERO);
  p_restore_value_r12: assert property (@(posedge clk) disable iff (!rst_n)
    phase == RST_RESTORE |-> ctrl_o == $past(ctrl_cfg, 3));
  p_clear_ctrl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |-> ctrl_o == '0);
endmodule

// File: rtl/cec_tx_sequencer.sv
module cec_tx_sequencer
  import cec_tx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CTRL_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              start_req,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy_o,
  output logic              done_o,
  output logic              refused_o,
  output logic              err_o,
  output logic              wake_o,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_start,
  output logic              tx_eom,
  output logic              tx_bcast,
  input  logic              frame_done,
  input  logic              frame_nak,
  input  logic              underrun,
  input  logic [CTRL_W-1:0] ctrl_cfg,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [MASK_W-1:0] irq_mask_o,
  output logic [IRQ_W-1:0]  irq_clr_o
);
  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  len_q;
  logic [MASK_W-1:0] mask_q;
  logic [IRQ_W-1:0]  clr_q;
  logic              done_q, refused_q, err_q, wake_q;
  logic [ADDR_W-1:0] hdr_addr;
  tx_tag_t           tag;
  logic              len_ok, start_ok, start_bad, hs, fdone, rst_trig, clr_all;

  assign busy_o    = (state != SEQ_IDLE);
  assign len_ok    = (start_len != '0) && (start_len <= LEN_W'(DEPTH));
  assign start_ok  = start_req && !busy_o && len_ok;
  assign start_bad = start_req && !busy_o && !len_ok;
  assign tx_valid  = (state == SEQ_SEND) && mask_q[IRQ_EMPTY];
  assign hs        = tx_valid && tx_ready;
  assign fdone     = frame_done && busy_o && mask_q[IRQ_DONE];
  assign rst_trig  = (fdone && frame_nak) || underrun;

  cec_msg_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .busy(busy_o), .clear_fill(start_ok),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_idx(idx), .rd_data(tx_data), .hdr_addr(hdr_addr)
  );

  cec_tag_gen #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tag (
    .idx(idx), .len(len_q), .hdr_addr(hdr_addr), .tag(tag)
  );

  cec_ctl_reset #(.CTRL_W(CTRL_W)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig(rst_trig), .ctrl_cfg(ctrl_cfg),
    .ctrl_o(ctrl_o), .clr_all(clr_all)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      idx       <= '0;
      len_q     <= '0;
      mask_q    <= '0;
      clr_q     <= '0;
      done_q    <= 1'b0;
      refused_q <= 1'b0;
      err_q     <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      clr_q  <= '0;
      done_q <= 1'b0;
      wake_q <= underrun;
      if (start_ok) begin
        state     <= SEQ_SEND;
        idx       <= '0;
        len_q     <= start_len;
        mask_q    <= '1;
        refused_q <= 1'b0;
        err_q     <= 1'b0;
      end else if (start_bad) begin
        err_q <= 1'b1;
      end
      if (hs) begin
        clr_q[IRQ_EMPTY] <= 1'b1;
        if (tag.eom) begin
          state             <= SEQ_WAIT;
          mask_q[IRQ_EMPTY] <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (fdone) begin
        state           <= SEQ_IDLE;
        mask_q          <= '0;
        done_q          <= 1'b1;
        clr_q[IRQ_DONE] <= 1'b1;
        if (frame_nak) begin
          clr_q[IRQ_NAK] <= 1'b1;
          refused_q      <= 1'b1;
        end
      end
    end
  end

  assign tx_start   = tag.start;
  assign tx_eom     = tag.eom;
  assign tx_bcast   = tag.bcast;
  assign done_o     = done_q;
  assign refused_o  = refused_q;
  assign err_o      = err_q;
  assign wake_o     = wake_q;
  assign irq_mask_o = mask_q;
  assign irq_clr_o  = clr_q | {IRQ_W{clr_all}};

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !frame_done |=> tx_valid && $stable(tx_data)
      && $stable(tx_eom) && $stable(tx_start));
  p_start_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hs && tx_start |=> !(tx_valid && tx_start));
  p_eom_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hs && tx_eom |=> !tx_valid);
  p_empty_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> irq_clr_o[IRQ_EMPTY]);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);
  p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> wake_o);
  p_busy_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_req && !frame_done |=> busy_o && !err_o);
endmodule

// File: tb/tb_cec_tx_sequencer.sv
`timescale 1ns/100ps
module tb_cec_tx_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_ready;
  logic [7:0]  in_data = '0;
  logic        start_req = 0;
  logic [4:0]  start_len = '0;
  logic        busy_o, done_o, refused_o, err_o, wake_o;
  logic        tx_valid, tx_ready = 0, tx_start, tx_eom, tx_bcast;
  logic [7:0]  tx_data;
  logic        frame_done = 0, frame_nak = 0, underrun = 0;
  logic [31:0] ctrl_cfg = 32'h0000_1234, ctrl_o;
  logic [2:0]  irq_mask_o;
  logic [3:0]  irq_clr_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cec_tx_sequencer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .start_req(start_req), .start_len(start_len),
    .busy_o(busy_o), .done_o(done_o), .refused_o(refused_o), .err_o(err_o),
    .wake_o(wake_o), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_start(tx_start), .tx_eom(tx_eom),
    .tx_bcast(tx_bcast), .frame_done(frame_done), .frame_nak(frame_nak),
    .underrun(underrun), .ctrl_cfg(ctrl_cfg), .ctrl_o(ctrl_o),
    .irq_mask_o(irq_mask_o), .irq_clr_o(irq_clr_o)
  );

  typedef struct packed {
    logic [4:0] len;
    logic [7:0] hdr;
    logic       nak;
    logic       stall;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{len: 5'd1,  hdr: 8'h4F, nak: 1'b0, stall: 1'b0},
    '{len: 5'd3,  hdr: 8'h12, nak: 1'b0, stall: 1'b1},
    '{len: 5'd16, hdr: 8'h3F, nak: 1'b1, stall: 1'b0},
    '{len: 5'd2,  hdr: 8'hA5, nak: 1'b1, stall: 1'b1},
    '{len: 5'd5,  hdr: 8'h0E, nak: 1'b0, stall: 1'b0}
  };

  function automatic logic [7:0] byte_of(logic [7:0] hdr, int i);
    return (i == 0) ? hdr : 8'(hdr + i * 37);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_msg(int len, logic [7:0] hdr);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = byte_of(hdr, i);
      #1 check("R1 in_ready while loading", 32'(in_ready), 32'd1);
    end
    @(negedge clk);
    in_valid = 0;
    #1 check("R1 in_ready after load", 32'(in_ready), 32'(len < 16));
  endtask

  task automatic start_msg(int len);
    @(negedge clk);
    start_req = 1; start_len = 5'(len);
    @(negedge clk);
    start_req = 0;
  endtask

  task automatic send_bytes(int len, logic [7:0] hdr, bit stall);
    for (int i = 0; i < len; i++) begin
      if (stall) begin
        tx_ready = 0;
        @(negedge clk);
        #1 check("R4 valid held under stall", 32'(tx_valid), 32'd1);
        check("R4 data held under stall", 32'(tx_data), 32'(byte_of(hdr, i)));
      end
      tx_ready = 1;
      #1 check("R4 tx_valid", 32'(tx_valid), 32'd1);
      check("R4 tx_data", 32'(tx_data), 32'(byte_of(hdr, i)));
      check("R5 start tag", 32'(tx_start), 32'(i == 0));
      check("R6 eom tag", 32'(tx_eom), 32'(i == len - 1));
      check("R7 bcast tag", 32'(tx_bcast), 32'(hdr[3:0] == 4'hF));
      @(negedge clk);
      tx_ready = 0;
      #1 check("R8 empty clear pulse", 32'(irq_clr_o[0]), 32'd1);
    end
    check("R8 valid low after last", 32'(tx_valid), 32'd0);
    check("R8 empty mask cleared", 32'(irq_mask_o[0]), 32'd0);
    check("R2 busy until done", 32'(busy_o), 32'd1);
  endtask

  task automatic finish_msg(bit nak);
    logic [31:0] old_cfg;
    old_cfg = ctrl_cfg;
    @(negedge clk);
    frame_done = 1; frame_nak = nak;
    @(negedge clk);
    frame_done = 0; frame_nak = 0;
    #1 check("R9 done pulse", 32'(done_o), 32'd1);
    check("R9 busy dropped", 32'(busy_o), 32'd0);
    check("R9 masks cleared", 32'(irq_mask_o), 32'd0);
    check("R9 sent clear", 32'(irq_clr_o[1]), 32'd1);
    check("R10 nak clear", 32'(irq_clr_o[2]), 32'(nak));
    check("R10 refused", 32'(refused_o), 32'(nak));
    if (nak) begin
      check("R12 ctrl zero phase", ctrl_o, 32'd0);
      ctrl_cfg = 32'hFFFF_0000;
      @(negedge clk);
      #1 check("R12 ctrl zero in clear", ctrl_o, 32'd0);
      check("R12 clear all", 32'(irq_clr_o), 32'hF);
      @(negedge clk);
      #1 check("R12 restore saved", ctrl_o, old_cfg);
      @(negedge clk);
      #1 check("R12 follows cfg", ctrl_o, 32'hFFFF_0000);
    end else begin
      check("R12 no reset without nak", ctrl_o, ctrl_cfg);
      @(negedge clk);
    end
    #1 check("R9 done is a pulse", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    check("R2 reset busy", 32'(busy_o), 32'd0);
    check("R4 reset tx_valid", 32'(tx_valid), 32'd0);
    check("R1 reset in_ready", 32'(in_ready), 32'd1);
    check("R3 reset err", 32'(err_o), 32'd0);
    check("R2 reset mask", 32'(irq_mask_o), 32'd0);
    check("R12 reset ctrl passthrough", ctrl_o, ctrl_cfg);

    // R3 illegal lengths
    start_msg(0);
    #1 check("R3 len 0 err", 32'(err_o), 32'd1);
    check("R3 len 0 idle", 32'(busy_o), 32'd0);
    start_msg(17);
    #1 check("R3 len 17 err", 32'(err_o), 32'd1);
    check("R3 len 17 idle", 32'(busy_o), 32'd0);
    check("R3 len 17 no mask", 32'(irq_mask_o), 32'd0);

    // R9 completion while idle
    @(negedge clk);
    frame_done = 1;
    @(negedge clk);
    frame_done = 0;
    #1 check("R9 idle done ignored", 32'(done_o), 32'd0);
    check("R9 idle no clear", 32'(irq_clr_o), 32'd0);

    for (int v = 0; v < NV; v++) begin
      ctrl_cfg = 32'hC0DE_0000 + 32'(v);
      load_msg(int'(VECS[v].len), VECS[v].hdr);
      start_msg(int'(VECS[v].len));
      #1 check("R2 busy after start", 32'(busy_o), 32'd1);
      check("R2 masks set", 32'(irq_mask_o), 32'd7);
      check("R3 err cleared", 32'(err_o), 32'd0);
      check("R10 refused cleared", 32'(refused_o), 32'd0);
      send_bytes(int'(VECS[v].len), VECS[v].hdr, VECS[v].stall);
      // R13 start while busy
      start_msg(3);
      #1 check("R13 busy kept", 32'(busy_o), 32'd1);
      check("R13 no err", 32'(err_o), 32'd0);
      check("R13 no resend", 32'(tx_valid), 32'd0);
      finish_msg(VECS[v].nak);
    end

    // R11 underrun mid-message
    ctrl_cfg = 32'h0000_5A5A;
    load_msg(2, 8'h61);
    start_msg(2);
    @(negedge clk);
    underrun = 1;
    @(negedge clk);
    underrun = 0;
    #1 check("R11 wake pulse", 32'(wake_o), 32'd1);
    check("R11 busy kept", 32'(busy_o), 32'd1);
    check("R11 reset zero", ctrl_o, 32'd0);
    @(negedge clk);
    #1 check("R11 wake one cycle", 32'(wake_o), 32'd0);
    check("R11 clear all", 32'(irq_clr_o), 32'hF);
    @(negedge clk);
    #1 check("R11 restore", ctrl_o, 32'h0000_5A5A);
    send_bytes(2, 8'h61, 1'b0);
    finish_msg(1'b0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule